// File: doc/BRIEF.md
# Eight-Source Two-Level Interrupt Controller

This block takes interrupt requests from eight sources and picks the one the processor core should service next. The sources are two original external pins, three timer overflows, a serial port flag and two added external pins. Each source has an enable bit and a priority bit that puts it in the high or the low level. A global enable gates every source. The winner's vector address is presented to the core, together with a request line.

The two added external pins have their own control register. It holds, for each pin, a trigger type, a request flag, an enable and a priority. In edge mode a falling edge on the synchronized pin sets the flag, and servicing that source clears it. In level mode the flag simply tracks the active-low pin. The register can be written as a whole byte or one bit at a time.

The core accepts the offered interrupt with an acknowledge strobe, which pushes the winner's level into the in-service state. A return-from-interrupt strobe pops that state. A high-level request may interrupt a low-level handler. Nothing interrupts a handler of the same or a higher level.

Top module: `irq8_ctrl`

## Requirements
- R1: After reset the control register reads 00H, the request line is low and no level is in service.
- R2: Source index k (0 = ext0, 1 = timer0, 2 = ext1, 3 = timer1, 4 = serial, 5 = timer2, 6 = ext2, 7 = ext3) has vector 8*k+3, i.e. 03H up to 3BH.
- R3: Among pending sources of the same level, the lowest index wins.
- R4: A pending high-level source wins over every low-level source, whatever its index.
- R5: A source raises a request only when its own enable and the global enable are both 1. Otherwise it has no effect on the request line.
- R6: Control register bits, 7 down to 0: ext3 priority, ext3 enable, ext3 flag, ext3 type, ext2 priority, ext2 enable, ext2 flag, ext2 type. A byte write replaces all the bits. A bit write (index 0..7, value) changes only the named bit. Either write is visible on the next cycle.
- R7: With type = 1, a falling edge of the pin, taken through a two-flop synchronizer, sets the flag three clock edges after the pin falls. The flag stays set after the pin returns high.
- R8: In edge mode, acknowledging that source clears its flag on the acknowledge edge.
- R9: With type = 0, the flag equals the inverted synchronized pin, with the same three-edge latency. An acknowledge leaves it unchanged.
- R10: While a high level is in service, no request is offered. While only a low level is in service, only high-level sources are offered.
- R11: A return strobe pops the high in-service level if it is set, and otherwise pops the low one. Requests blocked by the popped level are offered again on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| glb_en_i | input | 1 | Global interrupt enable |
| src_req_i | input | 6 | Request flags of sources 0..5 |
| src_en_i | input | 6 | Enables of sources 0..5 |
| src_pri_i | input | 6 | Priority bits of sources 0..5 (1 = high) |
| xpin_n_i | input | 2 | Added external pins, active low (bit 0 = ext2, bit 1 = ext3) |
| ctl_we_i | input | 1 | Byte write of the control register |
| ctl_wdata_i | input | 8 | Byte write data |
| bit_we_i | input | 1 | Single-bit write of the control register |
| bit_sel_i | input | 3 | Bit index for the single-bit write |
| bit_val_i | input | 1 | Value for the single-bit write |
| ctl_rdata_o | output | 8 | Control register contents, flags included |
| irq_o | output | 1 | Request to the core |
| vec_o | output | 8 | Vector address of the offered source |
| ack_i | input | 1 | Core accepts the offered interrupt |
| reti_i | input | 1 | Return from interrupt |

## Verification
On every cycle, assertions check several properties. The arbiter's grant must be one-hot and must name a pending source. Any offered vector must have the 8k+3 form. A high level in service or a cleared global enable must silence the request line. An acknowledge must always leave some level in service. Edge flags must set on a detected fall and clear on their own acknowledge. Only the bench scenarios can show the following: which source wins under each mix of priorities, the exact three-edge latency of the pin paths, that level-mode flags survive an acknowledge, and the order in which nested levels are popped.

// File: rtl/irq8_pkg.sv
package irq8_pkg;
  localparam int NSRC  = 8;
  localparam int IDX_W = $clog2(NSRC);
  localparam int VEC_W = 8;
  // control register bits that are stored in flops; flag bits come from the pin units
  localparam logic [7:0] CTL_STORE_MASK = 8'hDD;

  // vector address of a source: 8 * index + 3
  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    return VEC_W'((int'(idx) * 8) + 3);
  endfunction

  // merged image after a byte write and/or a single-bit write
  function automatic logic [7:0] merge_write(input logic [7:0] cur, input logic we,
                                             input logic [7:0] wd, input logic bwe,
                                             input logic [2:0] bsel, input logic bval);
    logic [7:0] img;
    img = we ? wd : cur;
    if (bwe) img[bsel] = bval;
    return img;
  endfunction
endpackage

// File: rtl/xint_line.sv
module xint_line #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic sw_we,
  input  logic sw_val,
  input  logic take,
  output logic flag
);
  logic [SYNC_DEPTH:0] sh_q;
  logic synced;
  logic fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= {sh_q[SYNC_DEPTH-1:0], pin_n};
  end

  assign synced = sh_q[SYNC_DEPTH-1];
  assign fall   = sh_q[SYNC_DEPTH] & ~synced;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            flag <= 1'b0;
    else if (!edge_mode)   flag <= ~synced;
    else if (fall)         flag <= 1'b1;
    else if (take)         flag <= 1'b0;
    else if (sw_we)        flag <= sw_val;
  end

  a_r7_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && fall) |=> flag);
  a_r8_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && take && !fall) |=> !flag);
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq8_pkg::*;
(
  input  logic [NSRC-1:0]  pend,
  input  logic [NSRC-1:0]  hi,
  output logic [NSRC-1:0]  grant,
  output logic [IDX_W-1:0] idx,
  output logic             lvl_hi,
  output logic             any
);
  logic [NSRC-1:0] hi_set;
  logic [NSRC-1:0] pool;

  assign hi_set = pend & hi;
  assign lvl_hi = |hi_set;
  assign pool   = lvl_hi ? hi_set : pend;
  assign any    = |pend;

  always_comb begin
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pool[i]) idx = IDX_W'(i);
    end
    grant = any ? (NSRC'(1) << idx) : '0;
  end
endmodule

// File: rtl/irq8_ctrl.sv
module irq8_ctrl
  import irq8_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       glb_en_i,
  input  logic [5:0] src_req_i,
  input  logic [5:0] src_en_i,
  input  logic [5:0] src_pri_i,
  input  logic [1:0] xpin_n_i,
  input  logic       ctl_we_i,
  input  logic [7:0] ctl_wdata_i,
  input  logic       bit_we_i,
  input  logic [2:0] bit_sel_i,
  input  logic       bit_val_i,
  output logic [7:0] ctl_rdata_o,
  output logic       irq_o,
  output logic [7:0] vec_o,
  input  logic       ack_i,
  input  logic       reti_i
);
  logic [7:0]       ctl_q;
  logic [7:0]       wr_img;
  logic [1:0]       xflag;
  logic [NSRC-1:0]  pend;
  logic [NSRC-1:0]  hi;
  logic [NSRC-1:0]  grant;
  logic [IDX_W-1:0] win_idx;
  logic             win_hi;
  logic             win_any;
  logic             take;
  logic             svc_hi_q, svc_lo_q;
  logic             svc_hi_d, svc_lo_d;

  assign wr_img = merge_write(ctl_rdata_o, ctl_we_i, ctl_wdata_i, bit_we_i, bit_sel_i, bit_val_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= wr_img & CTL_STORE_MASK;
  end

  assign ctl_rdata_o = (ctl_q & CTL_STORE_MASK) | {2'b00, xflag[1], 3'b000, xflag[0], 1'b0};

  // per-pin units: flag bits 1 (ext2) and 5 (ext3), type bits 0 and 4
  for (genvar g = 0; g < 2; g++) begin : g_xint
    localparam int BASE = 4 * g;
    xint_line #(.SYNC_DEPTH(SYNC_DEPTH)) u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_n     (xpin_n_i[g]),
      .edge_mode (ctl_q[BASE]),
      .sw_we     (ctl_we_i | bit_we_i),
      .sw_val    (wr_img[BASE+1]),
      .take      (take & grant[6+g]),
      .flag      (xflag[g])
    );
  end

  assign pend = {xflag[1] & ctl_q[6], xflag[0] & ctl_q[2], src_req_i & src_en_i}
                & {NSRC{glb_en_i}};
  assign hi   = {ctl_q[7], ctl_q[3], src_pri_i};

  irq_pick u_pick (
    .pend   (pend),
    .hi     (hi),
    .grant  (grant),
    .idx    (win_idx),
    .lvl_hi (win_hi),
    .any    (win_any)
  );

  assign irq_o = win_any && !svc_hi_q && (win_hi || !svc_lo_q);
  assign vec_o = vec_of(win_idx);
  assign take  = irq_o && ack_i;

  always_comb begin
    svc_hi_d = svc_hi_q;
    svc_lo_d = svc_lo_q;
    if (reti_i) begin
      if (svc_hi_q) svc_hi_d = 1'b0;
      else          svc_lo_d = 1'b0;
    end
    if (take) begin
      if (win_hi) svc_hi_d = 1'b1;
      else        svc_lo_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_hi_q <= 1'b0;
      svc_lo_q <= 1'b0;
    end else begin
      svc_hi_q <= svc_hi_d;
      svc_lo_q <= svc_lo_d;
    end
  end

  a_r3_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r4_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~pend) == '0);
  a_r2_vec_form: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (vec_o[2:0] == 3'b011));
  a_r5_global_off: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en_i |-> !irq_o);
  a_r10_hi_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    svc_hi_q |-> !irq_o);
  a_r11_ack_enters: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (svc_hi_q || svc_lo_q));
endmodule

// File: tb/irq8_ctrl_test.sv
module irq8_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       glb_en_i = 1'b0;
  logic [5:0] src_req_i = '0, src_en_i = '0, src_pri_i = '0;
  logic [1:0] xpin_n_i = 2'b11;
  logic       ctl_we_i = 1'b0, bit_we_i = 1'b0, bit_val_i = 1'b0;
  logic [7:0] ctl_wdata_i = '0;
  logic [2:0] bit_sel_i = '0;
  logic [7:0] ctl_rdata_o, vec_o;
  logic       irq_o, ack_i = 1'b0, reti_i = 1'b0;
  int         n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  irq8_ctrl uut (.*);

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic exp_irq, input int exp_vec, input string tag);
    #1;
    chk(irq_o == exp_irq, {tag, " irq"}, irq_o, exp_irq);
    if (exp_irq) chk(vec_o == exp_vec[7:0], {tag, " vec"}, vec_o, exp_vec);
  endtask

  task automatic pulse_ack();
    ack_i = 1'b1; step(1); ack_i = 1'b0;
  endtask

  task automatic pulse_reti();
    reti_i = 1'b1; step(1); reti_i = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] d);
    ctl_we_i = 1'b1; ctl_wdata_i = d; step(1); ctl_we_i = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    join_none

    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk(ctl_rdata_o == 8'h00, "R1 ctl", ctl_rdata_o, 0);
    chk_irq(1'b0, 0, "R1");

    // R5 / R2 sweep over single sources, enable and global enable
    for (int s = 0; s < 6; s++) begin
      for (int m = 0; m < 4; m++) begin
        src_req_i = 6'(1 << s);
        src_en_i  = m[0] ? 6'h3F : ~6'(1 << s);
        glb_en_i  = m[1];
        chk_irq(m[0] & m[1], 8 * s + 3, "R5 R2 single");
        @(negedge clk);
      end
    end

    // R3 / R4 sweep over pairs and priority mixes
    glb_en_i = 1'b1; src_en_i = 6'h3F;
    for (int i = 0; i < 6; i++) begin
      for (int j = i + 1; j < 6; j++) begin
        for (int p = 0; p < 4; p++) begin
          int w;
          src_req_i = 6'((1 << i) | (1 << j));
          src_pri_i = 6'((p[0] << i) | (p[1] << j));
          w = (p[1] && !p[0]) ? j : i;
          chk_irq(1'b1, 8 * w + 3, (p[1] && !p[0]) ? "R4 pair" : "R3 pair");
          @(negedge clk);
        end
      end
    end
    src_req_i = '0; src_pri_i = '0;

    // R6 byte write, R7 edge mode on ext2
    wr_byte(8'h05);
    chk(ctl_rdata_o == 8'h05, "R6 byte", ctl_rdata_o, 8'h05);
    xpin_n_i[0] = 1'b0;
    step(2);
    chk(ctl_rdata_o[1] == 1'b0, "R7 latency", ctl_rdata_o[1], 0);
    step(1);
    chk(ctl_rdata_o[1] == 1'b1, "R7 flag set", ctl_rdata_o[1], 1);
    chk_irq(1'b1, 8'h33, "R7 ext2");
    xpin_n_i[0] = 1'b1;
    step(3);
    chk(ctl_rdata_o[1] == 1'b1, "R7 held", ctl_rdata_o[1], 1);
    pulse_ack();
    chk(ctl_rdata_o[1] == 1'b0, "R8 cleared", ctl_rdata_o[1], 0);
    pulse_reti();

    // R9 level mode on ext3
    wr_byte(8'h40);
    xpin_n_i[1] = 1'b0;
    step(3);
    chk(ctl_rdata_o[5] == 1'b1, "R9 follows", ctl_rdata_o[5], 1);
    chk_irq(1'b1, 8'h3B, "R9 ext3");
    pulse_ack();
    chk(ctl_rdata_o[5] == 1'b1, "R9 ack kept", ctl_rdata_o[5], 1);
    pulse_reti();
    xpin_n_i[1] = 1'b1;
    step(3);
    chk(ctl_rdata_o[5] == 1'b0, "R9 released", ctl_rdata_o[5], 0);
    chk_irq(1'b0, 0, "R9 idle");

    // R6 bit writes
    bit_we_i = 1'b1; bit_sel_i = 3'd7; bit_val_i = 1'b1; step(1);
    bit_sel_i = 3'd6; bit_val_i = 1'b0; step(1); bit_we_i = 1'b0;
    chk(ctl_rdata_o == 8'h80, "R6 bit", ctl_rdata_o, 8'h80);
    wr_byte(8'h00);

    // R10 / R11 nesting
    src_req_i = 6'b100000;
    chk_irq(1'b1, 8'h2B, "R10 low offered");
    pulse_ack();
    src_req_i = 6'b000001;
    chk_irq(1'b0, 0, "R10 same level blocked");
    src_pri_i = 6'b000010; src_req_i = 6'b000011;
    chk_irq(1'b1, 8'h0B, "R10 high preempts");
    pulse_ack();
    src_pri_i = 6'b001000; src_req_i = 6'b001001;
    chk_irq(1'b0, 0, "R10 high blocks high");
    pulse_reti();
    chk_irq(1'b1, 8'h1B, "R11 pop high");
    src_req_i = 6'b000001;
    chk_irq(1'b0, 0, "R11 low still in service");
    pulse_reti();
    chk_irq(1'b1, 8'h03, "R11 pop low");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule